// File: doc/BRIEF.md
# Interval CRC-16 Stream Inserter

This block sits beside a switched I/O channel and decides when a 16-bit CRC has to be spliced into the byte stream. Each access starts with a byte tagged as first, the command byte. Three more header bytes follow: control byte 1, control byte 2 and an info byte. A two-bit field in control byte 1 picks the CRC interval for the whole access: no CRC, or one CRC after every 1, 8 or 32 data bytes.

After the header every accepted data byte is folded into the CRC register and counted, whichever way it travels. When the count reaches the interval, the block stops taking bytes and offers the two CRC bytes on a valid/ready handshake. It then clears the register and the counter and resumes. The first CRC of an access therefore covers the four header bytes and the first interval of data. Every later CRC covers only its own interval of data. A new first-tagged byte or a reset drops any partial interval and any pending CRC without emitting anything.

Top module: `crc_interval_ins`

## Requirements
- R1: The CRC uses the polynomial x^16 + x^15 + x^2 + 1 in reflected form (0xA001), shifting each byte in bit 0 first from a zero start. By this rule the nine ASCII bytes "123456789" give 0xBB3D.
- R2: A byte accepted with `byte_first_i` high opens an access, and the next three accepted bytes form the rest of the header. A byte with `byte_first_i` high is accepted in any state.
- R3: Bits [SEL_LSB+1:SEL_LSB] of the second header byte (SEL_LSB = 0 by default) select the interval: 00 none, 01 every data byte, 10 every MID_LEN (8) data bytes, 11 every LONG_LEN (32) data bytes. A CRC becomes pending in the cycle after the data byte that completes an interval is accepted.
- R4: The first CRC of an access is computed from a cleared register over the four header bytes and then the first interval of data bytes.
- R5: Each later CRC of the same access is computed from a cleared register over only the data bytes of its own interval.
- R6: `byte_dir_i` has no effect on counting or on the CRC. Data bytes in either direction, in any mix, advance the same interval.
- R7: A pending CRC is sent as two bytes on `crc_byte_o`, low byte first, each bitwise inverted. Each byte is held, with `crc_valid_o` high, until `crc_ready_i` takes it.
- R8: While a CRC is pending, `byte_ready_o` is low unless `byte_first_i` is high.
- R9: A new first-tagged byte cancels any partial interval and any pending CRC, and no CRC is emitted for the cancelled part.
- R10: With the interval field at 00, no CRC is ever offered during the access and every data byte is accepted.
- R11: After reset `crc_valid_o` is low, and no byte is accepted until a first-tagged byte arrives. A reset in the middle of an access discards it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid_i | input | 1 | Stream byte present |
| byte_first_i | input | 1 | Present byte is the command byte opening an access |
| byte_dir_i | input | 1 | Transfer direction of the byte (ignored by the CRC logic) |
| byte_data_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Stream byte is taken on this cycle when valid |
| crc_valid_o | output | 1 | A CRC byte is offered |
| crc_ready_i | input | 1 | Consumer takes the offered CRC byte |
| crc_byte_o | output | 8 | Offered CRC byte (inverted, low byte first) |

## Verification
The bench aims at the start of the first interval. A design that leaves the header bytes out, or that never clears the register after the first CRC, gives the wrong value in the first CRC or in a later one. It runs intervals of 1, 8 and 32, with the direction flag flipping inside a block. A counter that restarts on a direction change would then emit its CRC late or never. It cancels a partial block and a pending CRC with a new command byte, and also resets in mid-access. An inserter that kept stale state would offer a spurious CRC or accept bytes before the next command. It also holds off the consumer for several cycles. A design that swapped the byte order, left out the inversion, or let the offered byte drift during the stall is caught there.

// File: rtl/crc_interval_pkg.sv
package crc_interval_pkg;

    localparam int HDR_BYTES = 4;
    localparam int HDR_IW    = $clog2(HDR_BYTES);

    typedef enum logic [1:0] {
        SEL_OFF        = 2'b00,
        SEL_EVERY1     = 2'b01,
        SEL_EVERY_MID  = 2'b10,
        SEL_EVERY_LONG = 2'b11
    } crc_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_OUT_LO,
        ST_OUT_HI
    } ins_state_e;

    typedef struct packed {
        logic seed;     // restart CRC from zero with the present byte
        logic shift;    // fold present byte into running CRC
        logic clr;      // clear CRC after emission
        logic cnt_clr;  // clear interval counter
        logic cnt_inc;  // count one data byte
    } ctl_s;

    // One byte through a reflected CRC register, bit 0 first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                               input logic [7:0]  d,
                                               input logic [15:0] poly);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ poly;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_interval_lfsr.sv
module crc_interval_lfsr
    import crc_interval_pkg::*;
#(
    parameter logic [15:0] POLY = 16'hA001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        seed_i,
    input  logic        shift_i,
    input  logic        clr_i,
    input  logic [7:0]  data_i,
    output logic [15:0] crc_o
);

    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst)          crc_q <= '0;
        else if (seed_i)  crc_q <= crc16_step(16'h0000, data_i, POLY);
        else if (clr_i)   crc_q <= '0;
        else if (shift_i) crc_q <= crc16_step(crc_q, data_i, POLY);
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/crc_interval_cnt.sv
module crc_interval_cnt
    import crc_interval_pkg::*;
#(
    parameter int MID_LEN  = 8,
    parameter int LONG_LEN = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_i,
    input  logic     inc_i,
    input  crc_sel_e sel_i,
    output logic     last_o
);

    localparam int CW = $clog2(LONG_LEN + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        case (sel_i)
            SEL_EVERY1:     limit = CW'(1);
            SEL_EVERY_MID:  limit = CW'(MID_LEN);
            SEL_EVERY_LONG: limit = CW'(LONG_LEN);
            default:        limit = '0;
        endcase
    end

    assign last_o = (sel_i != SEL_OFF) && (cnt_q == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_q <= '0;
        else if (inc_i)   cnt_q <= last_o ? '0 : cnt_q + CW'(1);
    end

endmodule

// File: rtl/crc_interval_ctl.sv
module crc_interval_ctl
    import crc_interval_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_valid_i,
    input  logic       byte_first_i,
    input  logic [1:0] sel_field_i,
    input  logic       crc_ready_i,
    input  logic       last_i,
    output logic       byte_ready_o,
    output logic       crc_valid_o,
    output logic       out_hi_o,
    output crc_sel_e   sel_o,
    output ctl_s       ctl_o
);

    ins_state_e        state_q, state_d;
    crc_sel_e          sel_q, sel_d;
    logic [HDR_IW-1:0] hdr_idx_q, hdr_idx_d;
    logic              acc, take;

    assign byte_ready_o = byte_first_i || (state_q == ST_HDR) || (state_q == ST_DATA);
    assign crc_valid_o  = (state_q == ST_OUT_LO) || (state_q == ST_OUT_HI);
    assign out_hi_o     = (state_q == ST_OUT_HI);
    assign sel_o        = sel_q;
    assign acc          = byte_valid_i && byte_ready_o;
    assign take         = crc_valid_o && crc_ready_i;

    always_comb begin
        state_d   = state_q;
        sel_d     = sel_q;
        hdr_idx_d = hdr_idx_q;
        ctl_o     = '0;
        if (acc && byte_first_i) begin
            ctl_o.seed    = 1'b1;
            ctl_o.cnt_clr = 1'b1;
            hdr_idx_d     = HDR_IW'(1);
            state_d       = ST_HDR;
        end else if (acc && state_q == ST_HDR) begin
            ctl_o.shift = 1'b1;
            if (hdr_idx_q == HDR_IW'(1)) sel_d = crc_sel_e'(sel_field_i);
            if (hdr_idx_q == HDR_IW'(HDR_BYTES - 1)) state_d = ST_DATA;
            hdr_idx_d = hdr_idx_q + HDR_IW'(1);
        end else if (acc && state_q == ST_DATA) begin
            ctl_o.shift = 1'b1;
            if (sel_q != SEL_OFF) begin
                ctl_o.cnt_inc = 1'b1;
                if (last_i) state_d = ST_OUT_LO;
            end
        end else if (take && state_q == ST_OUT_LO) begin
            state_d = ST_OUT_HI;
        end else if (take && state_q == ST_OUT_HI) begin
            ctl_o.clr = 1'b1;
            state_d   = ST_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            sel_q     <= SEL_OFF;
            hdr_idx_q <= '0;
        end else begin
            state_q   <= state_d;
            sel_q     <= sel_d;
            hdr_idx_q <= hdr_idx_d;
        end
    end

endmodule

// File: rtl/crc_interval_ins.sv
module crc_interval_ins
    import crc_interval_pkg::*;
#(
    parameter int          MID_LEN  = 8,
    parameter int          LONG_LEN = 32,
    parameter int          SEL_LSB  = 0,
    parameter logic [15:0] POLY     = 16'hA001
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_valid_i,
    input  logic       byte_first_i,
    input  logic       byte_dir_i,
    input  logic [7:0] byte_data_i,
    output logic       byte_ready_o,
    output logic       crc_valid_o,
    input  logic       crc_ready_i,
    output logic [7:0] crc_byte_o
);

    ctl_s        ctl;
    crc_sel_e    sel;
    logic        last;
    logic        out_hi;
    logic [15:0] crc;

    crc_interval_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .byte_valid_i (byte_valid_i),
        .byte_first_i (byte_first_i),
        .sel_field_i  (byte_data_i[SEL_LSB +: 2]),
        .crc_ready_i  (crc_ready_i),
        .last_i       (last),
        .byte_ready_o (byte_ready_o),
        .crc_valid_o  (crc_valid_o),
        .out_hi_o     (out_hi),
        .sel_o        (sel),
        .ctl_o        (ctl)
    );

    crc_interval_cnt #(
        .MID_LEN  (MID_LEN),
        .LONG_LEN (LONG_LEN)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (ctl.cnt_clr),
        .inc_i  (ctl.cnt_inc),
        .sel_i  (sel),
        .last_o (last)
    );

    crc_interval_lfsr #(
        .POLY (POLY)
    ) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .seed_i  (ctl.seed),
        .shift_i (ctl.shift),
        .clr_i   (ctl.clr),
        .data_i  (byte_data_i),
        .crc_o   (crc)
    );

    assign crc_byte_o = out_hi ? ~crc[15:8] : ~crc[7:0];

endmodule

// File: rtl/crc_interval_ins_chk.sv
module crc_interval_ins_chk
    import crc_interval_pkg::*;
#(
    parameter int MID_LEN  = 8,
    parameter int LONG_LEN = 32,
    parameter int SEL_LSB  = 0
) (
    input logic       clk,
    input logic       rst,
    input logic       byte_valid_i,
    input logic       byte_first_i,
    input logic       byte_dir_i,
    input logic [7:0] byte_data_i,
    input logic       byte_ready_o,
    input logic       crc_valid_o,
    input logic       crc_ready_i,
    input logic [7:0] crc_byte_o
);

    localparam int CW = $clog2(LONG_LEN + 1);

    logic          ck_active, ck_last_dir;
    logic [2:0]    ck_hdr_left;
    logic [1:0]    ck_sel;
    logic [CW-1:0] ck_cnt, ck_n;
    logic          acc, acc_first, acc_data, at_edge;

    assign acc       = byte_valid_i && byte_ready_o;
    assign acc_first = acc && byte_first_i;
    assign acc_data  = acc && !byte_first_i && ck_active && (ck_hdr_left == 3'd0);
    assign at_edge   = (ck_cnt + CW'(1)) == ck_n;

    always_comb begin
        case (ck_sel)
            2'b01:   ck_n = CW'(1);
            2'b10:   ck_n = CW'(MID_LEN);
            2'b11:   ck_n = CW'(LONG_LEN);
            default: ck_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_active   <= 1'b0;
            ck_last_dir <= 1'b0;
            ck_hdr_left <= '0;
            ck_sel      <= '0;
            ck_cnt      <= '0;
        end else if (acc_first) begin
            ck_active   <= 1'b1;
            ck_hdr_left <= 3'(HDR_BYTES - 1);
            ck_cnt      <= '0;
        end else if (acc && ck_hdr_left != 3'd0) begin
            if (ck_hdr_left == 3'(HDR_BYTES - 1)) ck_sel <= byte_data_i[SEL_LSB +: 2];
            ck_hdr_left <= ck_hdr_left - 3'd1;
        end else if (acc_data) begin
            ck_last_dir <= byte_dir_i;
            if (ck_sel != 2'b00) ck_cnt <= at_edge ? '0 : ck_cnt + CW'(1);
        end
    end

    p_boundary_r3: assert property (@(posedge clk) disable iff (rst)
        acc_data && ck_sel != 2'b00 && at_edge |=> crc_valid_o);

    p_dir_change_r6: assert property (@(posedge clk) disable iff (rst)
        acc_data && (byte_dir_i != ck_last_dir) && ck_sel != 2'b00 && !at_edge |=> !crc_valid_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        crc_valid_o && !crc_ready_i && !acc_first |=> crc_valid_o && $stable(crc_byte_o));

    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        crc_valid_o && !byte_first_i |-> !byte_ready_o);

    p_cancel_r9: assert property (@(posedge clk) disable iff (rst)
        acc_first |=> !crc_valid_o);

    p_first_taken_r2: assert property (@(posedge clk) disable iff (rst)
        byte_first_i |-> byte_ready_o);

    p_off_r10: assert property (@(posedge clk) disable iff (rst)
        ck_active && ck_hdr_left == 3'd0 && ck_sel == 2'b00 |-> !crc_valid_o);

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !ck_active |-> !crc_valid_o && (byte_ready_o == byte_first_i));

endmodule

bind crc_interval_ins crc_interval_ins_chk #(
    .MID_LEN  (MID_LEN),
    .LONG_LEN (LONG_LEN),
    .SEL_LSB  (SEL_LSB)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_valid_i (byte_valid_i),
    .byte_first_i (byte_first_i),
    .byte_dir_i   (byte_dir_i),
    .byte_data_i  (byte_data_i),
    .byte_ready_o (byte_ready_o),
    .crc_valid_o  (crc_valid_o),
    .crc_ready_i  (crc_ready_i),
    .crc_byte_o   (crc_byte_o)
);

// File: tb/crc_interval_ins_tb.sv
module crc_interval_ins_tb;

    localparam int MID_LEN  = 8;
    localparam int LONG_LEN = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_valid_i = 1'b0;
    logic       byte_first_i = 1'b0;
    logic       byte_dir_i = 1'b0;
    logic [7:0] byte_data_i = 8'h00;
    logic       crc_ready_i = 1'b0;
    logic       byte_ready_o;
    logic       crc_valid_o;
    logic [7:0] crc_byte_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] m_crc = 16'h0;   // normal-domain (non-reflected) running value
    int          m_cnt = 0;
    logic [1:0]  m_sel = 2'b00;
    int          m_hdr_left = 0;
    bit          m_due = 1'b0;
    bit          m_first_blk = 1'b0;

    crc_interval_ins #(.MID_LEN(MID_LEN), .LONG_LEN(LONG_LEN)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .byte_valid_i (byte_valid_i),
        .byte_first_i (byte_first_i),
        .byte_dir_i   (byte_dir_i),
        .byte_data_i  (byte_data_i),
        .byte_ready_o (byte_ready_o),
        .crc_valid_o  (crc_valid_o),
        .crc_ready_i  (crc_ready_i),
        .crc_byte_o   (crc_byte_o)
    );

    always #4 clk = ~clk;

    // Non-reflected formulation (0x8005, MSB side) fed with bits in arrival order.
    function automatic logic [15:0] ref_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    function automatic logic [15:0] bitrev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    function automatic int blk_len(input logic [1:0] s);
        case (s)
            2'b01:   return 1;
            2'b10:   return MID_LEN;
            2'b11:   return LONG_LEN;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic put(input bit first, input logic [7:0] d, input bit dir,
                       input bit exp_rdy, input string tag);
        @(negedge clk);
        chk(m_due ? "R8" : "R10", "crc_valid_o before byte", {15'b0, crc_valid_o}, {15'b0, m_due});
        byte_valid_i = 1'b1;
        byte_first_i = first;
        byte_data_i  = d;
        byte_dir_i   = dir;
        #1;
        chk(tag, "byte_ready_o", {15'b0, byte_ready_o}, {15'b0, exp_rdy});
        @(posedge clk);
        #1;
        byte_valid_i = 1'b0;
        byte_first_i = 1'b0;
        if (exp_rdy) begin
            if (first) begin
                m_crc = ref_upd(16'h0, d);
                m_hdr_left = 3;
                m_cnt = 0;
                m_due = 1'b0;
                m_first_blk = 1'b1;
            end else begin
                m_crc = ref_upd(m_crc, d);
                if (m_hdr_left > 0) begin
                    if (m_hdr_left == 3) m_sel = d[1:0];
                    m_hdr_left--;
                end else if (m_sel != 2'b00) begin
                    m_cnt++;
                    if (m_cnt == blk_len(m_sel)) begin
                        m_cnt = 0;
                        m_due = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic take(input int stall);
        logic [15:0] exp;
        string       tag;
        exp = ~bitrev16(m_crc);
        tag = m_first_blk ? "R4" : "R5";
        @(negedge clk);
        chk("R3", "crc_valid_o at boundary", {15'b0, crc_valid_o}, 16'h1);
        chk("R8", "byte_ready_o while pending", {15'b0, byte_ready_o}, 16'h0);
        for (int s = 0; s < stall; s++) begin
            chk("R7", "low byte held during stall", {8'h0, crc_byte_o}, {8'h0, exp[7:0]});
            @(negedge clk);
        end
        crc_ready_i = 1'b1;
        #1;
        chk(tag, "crc low byte", {8'h0, crc_byte_o}, {8'h0, exp[7:0]});
        @(posedge clk);
        @(negedge clk);
        chk("R7", "crc_valid_o for high byte", {15'b0, crc_valid_o}, 16'h1);
        chk(tag, "crc high byte", {8'h0, crc_byte_o}, {8'h0, exp[15:8]});
        @(posedge clk);
        #1;
        crc_ready_i = 1'b0;
        m_crc = 16'h0;
        m_due = 1'b0;
        m_first_blk = 1'b0;
    endtask

    task automatic data(input logic [7:0] d, input bit dir, input int stall, input string tag);
        put(1'b0, d, dir, 1'b1, tag);
        if (m_due) take(stall);
    endtask

    task automatic header(input logic [7:0] cmd, input logic [7:0] c1,
                          input logic [7:0] c2, input logic [7:0] info);
        put(1'b1, cmd, 1'b0, 1'b1, "R2");
        put(1'b0, c1, 1'b0, 1'b1, "R2");
        put(1'b0, c2, 1'b0, 1'b1, "R2");
        put(1'b0, info, 1'b0, 1'b1, "R2");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        m_due = 1'b0;
        m_hdr_left = 0;
        m_cnt = 0;
        @(negedge clk);
        chk("R11", "crc_valid_o after reset", {15'b0, crc_valid_o}, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int          seed_dummy;
        string       s9;
        seed_dummy = $urandom(32'h5EED_1234);

        // R1: reference check value of the bench model
        s9 = "123456789";
        v = 16'h0;
        for (int i = 0; i < 9; i++) v = ref_upd(v, s9[i]);
        chk("R1", "check value of 123456789", bitrev16(v), 16'hBB3D);

        do_reset();
        // R11: non-first byte after reset is refused
        put(1'b0, 8'h55, 1'b0, 1'b0, "R11");

        // R3/R4/R5: interval 1, first CRC covers header
        header(8'hF5, 8'hFD, 8'h3C, 8'h81);
        data(8'h12, 1'b0, 0, "R4");
        data(8'h34, 1'b1, 2, "R5");
        data(8'hA7, 1'b0, 3, "R5");

        // R6: interval 8 with the direction flipping every byte
        header(8'hF5, 8'hA6, 8'h00, 8'h42);
        for (int i = 0; i < 24; i++) data(8'(i * 37 + 5), i[0], 1, "R6");

        // R3: interval 32 then R9 cancel of a partial block
        header(8'hF5, 8'h4B, 8'h11, 8'h22);
        for (int i = 0; i < 70; i++) data(8'($urandom), 1'($urandom), 0, "R3");
        header(8'hF5, 8'h02, 8'h00, 8'h00);
        for (int i = 0; i < 8; i++) data(8'(i + 1), 1'b1, 0, "R9");

        // R9: new command while a CRC is pending
        header(8'hF5, 8'h01, 8'h00, 8'h00);
        put(1'b0, 8'h99, 1'b0, 1'b1, "R9");
        put(1'b1, 8'hF5, 1'b0, 1'b1, "R9");
        @(negedge clk);
        chk("R9", "crc_valid_o after cancel", {15'b0, crc_valid_o}, 16'h0);
        put(1'b0, 8'h02, 1'b0, 1'b1, "R2");
        put(1'b0, 8'h00, 1'b0, 1'b1, "R2");
        put(1'b0, 8'h00, 1'b0, 1'b1, "R2");
        for (int i = 0; i < 16; i++) data(8'(i * 3), 1'b0, 0, "R4");

        // R10: interval field 00
        header(8'hF5, 8'h5C, 8'h00, 8'h00);
        for (int i = 0; i < 40; i++) data(8'($urandom), 1'($urandom), 0, "R10");

        // R11: reset in mid-access
        header(8'hF5, 8'h02, 8'h00, 8'h00);
        for (int i = 0; i < 5; i++) data(8'(i), 1'b0, 0, "R11");
        do_reset();
        put(1'b0, 8'h77, 1'b0, 1'b0, "R11");
        header(8'hF5, 8'h02, 8'hAB, 8'hCD);
        for (int i = 0; i < 8; i++) data(8'(i + 100), 1'b1, 0, "R4");

        // Random accesses
        for (int a = 0; a < 12; a++) begin
            int n;
            header(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            n = $urandom % 70;
            for (int i = 0; i < n; i++) data(8'($urandom), 1'($urandom), $urandom % 3, "R5");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule